// File: doc/BRIEF.md
# Reference Ramp Sequencer for Start-Up and Shutdown

This block drives the digital reference code that a regulator's error comparator follows while the output is brought up and taken down. When the converter is allowed to run, the code climbs from zero to full scale at a fixed rate set by a clock-cycle count, so the start-up time does not depend on how fast the power stage switches. When the converter is told to stop, or a fault asks for shutdown, the code falls back to zero at a slower rate. This lets the output capacitors discharge under control instead of collapsing at once.

An output may still hold charge when a new start begins. To handle this, the sequencer keeps the gate drivers inhibited until an external comparator reports that the rising code has caught up with the feedback voltage. Switching then starts from that level. A supply-good input overrides everything: when it is low, the sequencer is held idle with a zero code. Step periods come from the clock frequency and the rise and fall durations, divided by the number of code steps.

Top module: `reframp_seq`

## Requirements
- R1: After reset, `ref_code` is 0 and `sw_permit`, `ss_done` and `stop_active` are all low.
- R2: A rise starts only while `en_req` is high, `por_ok` is high and no fault is latched. Otherwise `ref_code` stays at 0.
- R3: During a rise, `ref_code` goes up by exactly one LSB every START_STEP clock cycles, where START_STEP = (CLK_KHZ*START_US/1000)/(2^CODE_W-1). Counting from the first clock edge that sees the start condition, full scale (2^CODE_W-1) is reached after (2^CODE_W-1)*START_STEP cycles.
- R4: While the code rises, `sw_permit` stays low until `fb_reached` (high means code has reached feedback) is sampled high. It rises one cycle later and then stays high until the ramp ends at zero, a fault occurs or `por_ok` drops.
- R5: `ss_done` rises in the same cycle that `ref_code` reaches full scale. It stays high until a stop begins.
- R6: When `en_req` goes low, `stop_active` rises and `ss_done` falls on the next edge. `ref_code` then falls by one LSB every STOP_STEP = (CLK_KHZ*STOP_US/1000)/(2^CODE_W-1) cycles while `sw_permit` is held. One cycle after the code reaches 0, the block goes idle with `stop_active` and `sw_permit` low.
- R7: A high `fault_stop` while `en_req` is high starts the falling ramp and clears `sw_permit` on the next edge. The fault is latched, so no new rise begins until `en_req` has been low.
- R8: If `en_req` returns high during a falling ramp caused by enable, the code climbs again from its present value without first going to zero.
- R9: Whenever `por_ok` is low, the next edge forces `ref_code` to 0 and all flag outputs low, whatever the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Ramp timing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_req | input | 1 | Enable request (high = run) |
| por_ok | input | 1 | Supply power-on-reset good |
| fault_stop | input | 1 | Shutdown request from under-voltage or over-temperature logic |
| fb_reached | input | 1 | Comparator: reference code has reached the feedback level |
| ref_code | output | CODE_W | Reference code to the DAC |
| sw_permit | output | 1 | Gate drivers may switch |
| ss_done | output | 1 | Start-up ramp has reached full scale |
| stop_active | output | 1 | Falling ramp in progress |

## Verification
The hardest case to reach is the reversal. Enable must come back while the falling ramp sits partway down, and the code must not first drop to zero. The bench gets there by running a full rise, dropping enable, and watching the code until it reads a chosen mid value, then raising enable at that point. It then checks that the code never dips below that value and that full scale arrives after exactly the remaining number of rise steps. A pre-biased output is modelled by deriving `fb_reached` from the code against a chosen level. This checks that `sw_permit` stays low right up to the matching step.

// File: rtl/reframp_pkg.sv
package reframp_pkg;

   typedef enum logic [1:0] {
      RS_IDLE = 2'd0,
      RS_UP   = 2'd1,
      RS_FULL = 2'd2,
      RS_DOWN = 2'd3
   } rs_state_e;

   // Clock cycles per code step for a ramp of dur_us microseconds.
   function automatic int unsigned step_cycles(input int unsigned clk_khz,
                                               input int unsigned dur_us,
                                               input int unsigned steps);
      return (clk_khz * dur_us / 1000) / steps;
   endfunction

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/reframp_step_timer.sv
module reframp_step_timer #(
   parameter int unsigned UP_LIM = 2,
   parameter int unsigned DN_LIM = 16,
   localparam int unsigned MAX_LIM = reframp_pkg::max_u(UP_LIM, DN_LIM),
   localparam int unsigned CNT_W = $clog2(MAX_LIM + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic dir_up,
   input  logic restart,
   output logic tick
);

   localparam logic [CNT_W-1:0] UP_LAST = CNT_W'(UP_LIM - 1);
   localparam logic [CNT_W-1:0] DN_LAST = CNT_W'(DN_LIM - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;

   generate
      if (UP_LIM == DN_LIM) begin : g_shared
         assign last = UP_LAST;
         logic unused_dir;
         assign unused_dir = dir_up;
      end else begin : g_split
         assign last = dir_up ? UP_LAST : DN_LAST;
      end
   endgenerate

   assign tick = run && (cnt_q == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart || !run || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/reframp_code_acc.sv
module reframp_code_acc #(
   parameter int unsigned CODE_W = 10,
   localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              inc,
   input  logic              dec,
   output logic [CODE_W-1:0] code,
   output logic              near_top,
   output logic              at_zero
);

   logic [CODE_W-1:0] code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
      end else if (clr) begin
         code_q <= '0;
      end else if (inc && (code_q != FULL)) begin
         code_q <= code_q + 1'b1;
      end else if (dec && (code_q != '0)) begin
         code_q <= code_q - 1'b1;
      end
   end

   assign code     = code_q;
   assign near_top = (code_q == FULL - 1'b1);
   assign at_zero  = (code_q == '0);

endmodule

// File: rtl/reframp_ctrl.sv
module reframp_ctrl
   import reframp_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic en_req,
   input  logic por_ok,
   input  logic fault_stop,
   input  logic fb_reached,
   input  logic tick,
   input  logic near_top,
   input  logic at_zero,
   output logic run,
   output logic dir_up,
   output logic restart,
   output logic inc,
   output logic dec,
   output logic clr,
   output logic sw_permit,
   output logic ss_done,
   output logic stop_active
);

   rs_state_e st_q, st_d;
   logic      fault_q;
   logic      permit_q;
   logic      fault_now;
   logic      go;

   // A fault is held until enable is withdrawn or the supply drops.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_q <= 1'b0;
      end else if (!por_ok || !en_req) begin
         fault_q <= 1'b0;
      end else if (fault_stop) begin
         fault_q <= 1'b1;
      end
   end

   assign fault_now = fault_q || (fault_stop && en_req);
   assign go        = en_req && por_ok && !fault_now;

   always_comb begin
      st_d = st_q;
      if (!por_ok) begin
         st_d = RS_IDLE;
      end else begin
         unique case (st_q)
            RS_IDLE: if (go) st_d = RS_UP;
            RS_UP: begin
               if (!go)                   st_d = RS_DOWN;
               else if (tick && near_top) st_d = RS_FULL;
            end
            RS_FULL: if (!go) st_d = RS_DOWN;
            RS_DOWN: begin
               if (go)           st_d = RS_UP;
               else if (at_zero) st_d = RS_IDLE;
            end
            default: st_d = RS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= RS_IDLE;
      end else begin
         st_q <= st_d;
      end
   end

   assign run     = (st_q == RS_UP) || (st_q == RS_DOWN);
   assign dir_up  = (st_q == RS_UP);
   assign restart = (st_d != st_q);
   assign clr     = !por_ok;
   assign inc     = (st_q == RS_UP) && go && tick;
   assign dec     = (st_q == RS_DOWN) && !go && !at_zero && tick && por_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         permit_q <= 1'b0;
      end else if (!por_ok || fault_now) begin
         permit_q <= 1'b0;
      end else if ((st_q == RS_DOWN) && at_zero && !go) begin
         permit_q <= 1'b0;
      end else if ((st_q == RS_UP) && fb_reached) begin
         permit_q <= 1'b1;
      end
   end

   assign sw_permit   = permit_q;
   assign ss_done     = (st_q == RS_FULL);
   assign stop_active = (st_q == RS_DOWN);

endmodule

// File: rtl/reframp_seq.sv
module reframp_seq #(
   parameter int unsigned CODE_W   = 10,
   parameter int unsigned CLK_KHZ  = 50000,
   parameter int unsigned START_US = 1000,
   parameter int unsigned STOP_US  = 8000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_req,
   input  logic              por_ok,
   input  logic              fault_stop,
   input  logic              fb_reached,
   output logic [CODE_W-1:0] ref_code,
   output logic              sw_permit,
   output logic              ss_done,
   output logic              stop_active
);

   localparam int unsigned STEPS      = (1 << CODE_W) - 1;
   localparam int unsigned START_STEP = reframp_pkg::step_cycles(CLK_KHZ, START_US, STEPS);
   localparam int unsigned STOP_STEP  = reframp_pkg::step_cycles(CLK_KHZ, STOP_US, STEPS);

   generate
      if (CODE_W < 2 || CODE_W > 16) begin : g_bad_width
         $error("reframp_seq: CODE_W must be in 2..16");
      end
      if (START_STEP < 1) begin : g_bad_start
         $error("reframp_seq: rise duration shorter than one cycle per step");
      end
      if (STOP_STEP < 1) begin : g_bad_stop
         $error("reframp_seq: fall duration shorter than one cycle per step");
      end
   endgenerate

   logic tick, near_top, at_zero;
   logic run, dir_up, restart, inc, dec, clr;

   reframp_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_req     (en_req),
      .por_ok     (por_ok),
      .fault_stop (fault_stop),
      .fb_reached (fb_reached),
      .tick       (tick),
      .near_top   (near_top),
      .at_zero    (at_zero),
      .run        (run),
      .dir_up     (dir_up),
      .restart    (restart),
      .inc        (inc),
      .dec        (dec),
      .clr        (clr),
      .sw_permit  (sw_permit),
      .ss_done    (ss_done),
      .stop_active(stop_active)
   );

   reframp_step_timer #(
      .UP_LIM(START_STEP),
      .DN_LIM(STOP_STEP)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .dir_up (dir_up),
      .restart(restart),
      .tick   (tick)
   );

   reframp_code_acc #(
      .CODE_W(CODE_W)
   ) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .inc     (inc),
      .dec     (dec),
      .code    (ref_code),
      .near_top(near_top),
      .at_zero (at_zero)
   );

endmodule

// File: rtl/reframp_chk.sv
module reframp_chk #(
   parameter int unsigned CODE_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en_req,
   input logic              por_ok,
   input logic              fault_stop,
   input logic              fb_reached,
   input logic [CODE_W-1:0] ref_code,
   input logic              sw_permit,
   input logic              ss_done,
   input logic              stop_active
);

   localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}};

   // R3 / R6: code only moves by single steps while supply is good
   p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (por_ok && $past(por_ok) && (ref_code != $past(ref_code))) |->
         ((ref_code == $past(ref_code) + 1'b1) || (ref_code + 1'b1 == $past(ref_code))));

   // R4: switching permission only follows a reached comparator
   p_permit_after_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_permit) |-> $past(fb_reached));

   // R5: done flag rises only at full scale
   p_done_at_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ss_done) |-> (ref_code == FULL));

   // R6: stopping and done are exclusive
   p_stop_not_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      stop_active |-> !ss_done);

   // R7: a fault request removes switching permission on the next edge
   p_fault_drops_permit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_stop && en_req) |=> !sw_permit);

   // R9: supply loss clears everything on the next edge
   p_por_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !por_ok |=> ((ref_code == '0) && !sw_permit && !ss_done && !stop_active));

endmodule

bind reframp_seq reframp_chk #(.CODE_W(CODE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .en_req     (en_req),
   .por_ok     (por_ok),
   .fault_stop (fault_stop),
   .fb_reached (fb_reached),
   .ref_code   (ref_code),
   .sw_permit  (sw_permit),
   .ss_done    (ss_done),
   .stop_active(stop_active)
);

// File: tb/sim_reframp_seq.sv
module sim_reframp_seq;

   localparam int CODE_W = 10;
   localparam int FULLV  = 1023;
   localparam int UPS    = 2;    // START_STEP with CLK_KHZ=2046
   localparam int DNS    = 16;   // STOP_STEP with CLK_KHZ=2046

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              en_req = 1'b0;
   logic              por_ok = 1'b1;
   logic              fault_stop = 1'b0;
   logic              fb_reached;
   logic [CODE_W-1:0] ref_code;
   logic              sw_permit, ss_done, stop_active;
   int                fb_lvl = 0;
   int                n_chk = 0;
   int                n_bad = 0;

   assign fb_reached = (int'(ref_code) >= fb_lvl);

   always #2 clk = ~clk;

   reframp_seq #(.CODE_W(CODE_W), .CLK_KHZ(2046), .START_US(1000), .STOP_US(8000)) u0 (
      .clk(clk), .rst_n(rst_n), .en_req(en_req), .por_ok(por_ok),
      .fault_stop(fault_stop), .fb_reached(fb_reached), .ref_code(ref_code),
      .sw_permit(sw_permit), .ss_done(ss_done), .stop_active(stop_active));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic quick_idle();
      @(negedge clk); en_req = 1'b0; fault_stop = 1'b0; por_ok = 1'b0;
      @(negedge clk); por_ok = 1'b1; fb_lvl = 0;
      @(negedge clk);
   endtask

   task automatic rise_to_full();
      int c = 0;
      @(negedge clk); en_req = 1'b1;
      while (!ss_done && c < 5000) begin step(); c++; end
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk(ref_code == 0 && !sw_permit && !ss_done && !stop_active, "R1 reset outputs",
          {ref_code, sw_permit, ss_done, stop_active}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_blocked();
      @(negedge clk); por_ok = 1'b0; en_req = 1'b1;
      repeat (50) step();
      chk(ref_code == 0 && !stop_active, "R2 no rise without por_ok", int'(ref_code), 0);
      quick_idle();
   endtask

   task automatic t_start();
      int c = 0;
      @(negedge clk); fb_lvl = 0; en_req = 1'b1;
      while (!ss_done && c < 5000) begin
         step(); c++;
         if (c == 2) chk(sw_permit == 1'b1, "R4 permit one cycle after match", sw_permit, 1);
         if (c == 1 + UPS*100) chk(ref_code == 100, "R3 code mid rise", int'(ref_code), 100);
      end
      chk(c == 1 + UPS*FULLV, "R3 rise duration", c, 1 + UPS*FULLV);
      chk(ref_code == FULLV, "R5 done at full scale", int'(ref_code), FULLV);
      repeat (20) step();
      chk(ss_done == 1'b1, "R5 done held", ss_done, 1);
   endtask

   task automatic t_stop();
      int c = 0;
      @(negedge clk); en_req = 1'b0;
      step(); c++;
      chk(stop_active && !ss_done, "R6 stop entered, done cleared", {stop_active, ss_done}, 2);
      while (stop_active && c < 20000) begin
         step(); c++;
         if (c == 1 + DNS*10) begin
            chk(ref_code == FULLV - 10, "R6 code mid fall", int'(ref_code), FULLV - 10);
            chk(sw_permit == 1'b1, "R6 permit held while falling", sw_permit, 1);
         end
      end
      chk(c == 2 + DNS*FULLV, "R6 fall duration", c, 2 + DNS*FULLV);
      chk(ref_code == 0 && !sw_permit, "R6 idle after fall", {ref_code, sw_permit}, 0);
   endtask

   task automatic t_prebias();
      int c = 0;
      bit early = 1'b0;
      @(negedge clk); fb_lvl = 300; en_req = 1'b1;
      while (ref_code != 300 && c < 5000) begin
         step(); c++;
         if (sw_permit) early = 1'b1;
      end
      chk(!early && !sw_permit, "R4 permit low below pre-bias", sw_permit, 0);
      step();
      chk(sw_permit == 1'b1, "R4 permit after pre-bias match", sw_permit, 1);
      quick_idle();
   endtask

   task automatic t_reverse();
      int c = 0;
      int lo;
      rise_to_full();
      @(negedge clk); en_req = 1'b0;
      while (ref_code != 900 && c < 5000) begin step(); c++; end
      @(negedge clk); en_req = 1'b1;
      lo = int'(ref_code);
      c = 0;
      while (!ss_done && c < 5000) begin
         step(); c++;
         if (int'(ref_code) < lo) lo = int'(ref_code);
      end
      chk(lo == 900, "R8 no drop on reversal", lo, 900);
      chk(c == 1 + UPS*(FULLV - 900), "R8 climb from present code", c, 1 + UPS*(FULLV - 900));
      quick_idle();
   endtask

   task automatic t_fault();
      int c = 0;
      rise_to_full();
      @(negedge clk); fault_stop = 1'b1;
      @(negedge clk); fault_stop = 1'b0;
      chk(stop_active && !sw_permit, "R7 fault stop drops permit", {stop_active, sw_permit}, 2);
      while (stop_active && c < 20000) begin step(); c++; end
      repeat (100) step();
      chk(ref_code == 0 && !stop_active, "R7 latched fault blocks restart", int'(ref_code), 0);
      @(negedge clk); en_req = 1'b0;
      @(negedge clk); en_req = 1'b1;
      repeat (10) step();
      chk(ref_code != 0, "R2 restart after enable toggle", int'(ref_code), 4);
      quick_idle();
   endtask

   task automatic t_por();
      int c = 0;
      @(negedge clk); en_req = 1'b1;
      while (ref_code != 500 && c < 5000) begin step(); c++; end
      @(negedge clk); por_ok = 1'b0;
      step();
      chk(ref_code == 0 && !sw_permit && !ss_done && !stop_active, "R9 supply loss clears",
          {ref_code, sw_permit, ss_done, stop_active}, 0);
      @(negedge clk); por_ok = 1'b1;
      repeat (10) step();
      chk(ref_code != 0, "R2 rise resumes with supply good", int'(ref_code), 4);
      quick_idle();
   endtask

   initial begin
      t_reset();
      t_blocked();
      t_start();
      t_stop();
      t_prebias();
      t_reverse();
      t_fault();
      t_por();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule